// File: doc/BRIEF.md
# SPI Register Command Decoder

This block is a SPI slave for mode 0 that sits between an external SPI master and an internal register bus. It collects bytes most significant bit first, decodes the first byte of each chip-select frame as an opcode, and turns valid frames into single-cycle write or read strobes. The register bus carries an 8-bit address, 8-bit write data and 8-bit read data. A fixed revision byte can be read back without touching the register bus. Two opcodes switch the activity LED indication on and off.

All SPI pins are brought into the system clock domain through two-flop synchronisers, and edges are found there. SCLK must run at no more than one quarter of the system clock. A frame begins when chip select falls and ends when it rises. Bytes left over after a complete command, unknown opcodes, bad stuffing bytes and frames cut short by chip select are all discarded without side effects.

Top module: `spi_cmd_decoder`

## Requirements
- R1: After reset, spi_miso is 1, led_n is 1, reg_wr and reg_rd are 0, and the LED indication is enabled.
- R2: Bits are taken from spi_mosi on rising SCLK edges and placed on spi_miso after falling SCLK edges. Every byte in both directions moves most significant bit first.
- R3: The frame 0x01, address, data produces exactly one reg_wr pulse carrying that address and data. The pulse follows the eighth bit of the third byte while chip select is still low.
- R4: A write frame that loses chip select before the eighth bit of its data byte produces no reg_wr, and the addressed register keeps its old value.
- R5: The frame 0x05, address, 0xFF, then one more byte produces one reg_rd pulse carrying the address. reg_rdata is sampled on the clock edge that ends the reg_rd cycle and is shifted out on spi_miso during the fourth byte.
- R6: A read frame whose third byte is not 0xFF produces no reg_rd, and spi_miso stays 1 for the rest of the frame.
- R7: The frame 0x9F, 0xFF, then one more byte returns the REV_ID parameter (default 0x3A) during its third byte and produces no register strobe.
- R8: Opcode 0x06 disables the LED indication, which keeps led_n at 1 in later frames. Opcode 0x04 enables it again.
- R9: While the indication is enabled, led_n is 0 during a frame (chip select low) and 1 between frames.
- R10: A frame whose opcode is none of 0x01, 0x05, 0x9F, 0x04 or 0x06 produces no strobes, returns 0xFF on every byte, and ignores its remaining bytes even if they look like a command.
- R11: spi_miso is 1 at all times except during the returned data byte of a read or revision frame.
- R12: reg_wr and reg_rd are each one clock wide and are never high together.
- R13: Bytes that follow a completed command in the same frame have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| spi_sclk | input | 1 | SPI clock from the master (asynchronous) |
| spi_mosi | input | 1 | Serial data from the master |
| spi_cs_n | input | 1 | Chip select, active low |
| spi_miso | output | 1 | Serial data to the master |
| led_n | output | 1 | Activity LED, active low |
| reg_addr | output | 8 | Register bus address |
| reg_wdata | output | 8 | Register bus write data |
| reg_wr | output | 1 | Register write strobe, one cycle |
| reg_rd | output | 1 | Register read strobe, one cycle |
| reg_rdata | input | 8 | Register read data, sampled at the end of the reg_rd cycle |

## Verification
The bench targets frames that stop early. A write cut off inside its data byte must leave the register untouched, and a read-back through the normal path confirms that. A design that fired the strobe on the address byte, or on a partial byte, would corrupt the register. Bad stuffing bytes and unknown opcodes are followed in the same frame by bytes that form a valid write. A decoder that resynchronised on those bytes instead of discarding the frame would issue a write. Further cases are extra bytes after a complete write or read, the LED off and on opcodes across later frames, and read data arriving MSB first on the fourth byte. A slip in the shift timing would show up there as a rotated or shifted value.

// File: rtl/spicd_pkg.sv
package spicd_pkg;

    localparam int BYTE_W = 8;
    localparam int BIT_CW = $clog2(BYTE_W);

    localparam logic [BYTE_W-1:0] OPC_WR_REG  = 8'h01;
    localparam logic [BYTE_W-1:0] OPC_RD_REG  = 8'h05;
    localparam logic [BYTE_W-1:0] OPC_REV     = 8'h9F;
    localparam logic [BYTE_W-1:0] OPC_LED_OFF = 8'h06;
    localparam logic [BYTE_W-1:0] OPC_LED_ON  = 8'h04;
    localparam logic [BYTE_W-1:0] FILL_BYTE   = 8'hFF;

    typedef enum logic [3:0] {
        ST_IDLE,     // waiting for opcode byte (or chip select high)
        ST_WADDR,
        ST_WDATA,
        ST_RADDR,
        ST_RFILL,
        ST_IFILL,
        ST_XFER,     // data byte going out on MISO
        ST_SKIP      // rest of frame discarded
    } cmd_state_e;

    typedef struct packed {
        logic act;   // chip select low (synchronised)
        logic rise;  // SCLK rising edge seen this cycle
        logic fall;  // SCLK falling edge seen this cycle
    } spi_evt_t;

    function automatic logic is_fill(input logic [BYTE_W-1:0] b);
        return b == FILL_BYTE;
    endfunction

endpackage

// File: rtl/spicd_sync.sv
module spicd_sync #(
    parameter int         W       = 3,
    parameter int         STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    generate
        for (genvar g = 0; g < W; g++) begin : g_bit
            logic [STAGES-1:0] chain;
            always_ff @(posedge clk) begin
                if (rst) chain <= {STAGES{RST_VAL[g]}};
                else     chain <= {chain[STAGES-2:0], d[g]};
            end
            assign q[g] = chain[STAGES-1];
        end
    endgenerate
endmodule

// File: rtl/spicd_bitio.sv
module spicd_bitio
    import spicd_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              sclk_s,
    input  logic              mosi_s,
    input  logic              csn_s,
    input  logic              tx_load,
    input  logic [BYTE_W-1:0] tx_data,
    output spi_evt_t          evt,
    output logic              byte_done,
    output logic [BYTE_W-1:0] rx_byte,
    output logic              miso
);
    localparam logic [BIT_CW-1:0] LAST_BIT = BIT_CW'(BYTE_W - 1);

    logic              sclk_q;
    logic [BIT_CW-1:0] bit_cnt;
    logic [BYTE_W-1:0] rx_sh;
    logic [BYTE_W-1:0] tx_sh;
    logic              miso_q;

    always_comb begin
        evt.act  = ~csn_s;
        evt.rise = ~csn_s &  sclk_s & ~sclk_q;
        evt.fall = ~csn_s & ~sclk_s &  sclk_q;
    end

    assign byte_done = evt.rise && (bit_cnt == LAST_BIT);
    assign rx_byte   = {rx_sh[BYTE_W-2:0], mosi_s};
    assign miso      = miso_q;

    always_ff @(posedge clk) begin
        if (rst) sclk_q <= 1'b0;
        else     sclk_q <= sclk_s;
    end

    // receive side: counter and shifter restart with every frame
    always_ff @(posedge clk) begin
        if (rst || !evt.act) begin
            bit_cnt <= '0;
            rx_sh   <= '0;
        end else if (evt.rise) begin
            rx_sh   <= rx_byte;
            bit_cnt <= (bit_cnt == LAST_BIT) ? '0 : bit_cnt + 1'b1;
        end
    end

    // transmit side: ones shift in behind the data, so idle MISO is 1
    always_ff @(posedge clk) begin
        if (rst || !evt.act) begin
            tx_sh  <= '1;
            miso_q <= 1'b1;
        end else if (tx_load) begin
            tx_sh  <= tx_data;
        end else if (evt.fall) begin
            miso_q <= tx_sh[BYTE_W-1];
            tx_sh  <= {tx_sh[BYTE_W-2:0], 1'b1};
        end
    end
endmodule

// File: rtl/spicd_cmd_fsm.sv
module spicd_cmd_fsm
    import spicd_pkg::*;
#(
    parameter logic [BYTE_W-1:0] REV_ID = 8'h3A
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              act,
    input  logic              byte_done,
    input  logic [BYTE_W-1:0] rx_byte,
    input  logic [BYTE_W-1:0] reg_rdata,
    output logic [BYTE_W-1:0] reg_addr,
    output logic [BYTE_W-1:0] reg_wdata,
    output logic              reg_wr,
    output logic              reg_rd,
    output logic              tx_load,
    output logic [BYTE_W-1:0] tx_data,
    output logic              led_en
);
    cmd_state_e        state;
    logic              wr_q;
    logic              ld_q;
    logic              ld_rev_q;
    logic [BYTE_W-1:0] addr_q;
    logic [BYTE_W-1:0] wdata_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            wr_q     <= 1'b0;
            ld_q     <= 1'b0;
            ld_rev_q <= 1'b0;
            addr_q   <= '0;
            wdata_q  <= '0;
            led_en   <= 1'b1;
        end else begin
            wr_q <= 1'b0;
            ld_q <= 1'b0;
            if (!act) begin
                state <= ST_IDLE;
            end else if (byte_done) begin
                unique case (state)
                    ST_IDLE: begin
                        unique case (rx_byte)
                            OPC_WR_REG:  state <= ST_WADDR;
                            OPC_RD_REG:  state <= ST_RADDR;
                            OPC_REV:     state <= ST_IFILL;
                            OPC_LED_OFF: begin led_en <= 1'b0; state <= ST_SKIP; end
                            OPC_LED_ON:  begin led_en <= 1'b1; state <= ST_SKIP; end
                            default:     state <= ST_SKIP;
                        endcase
                    end
                    ST_WADDR: begin
                        addr_q <= rx_byte;
                        state  <= ST_WDATA;
                    end
                    ST_WDATA: begin
                        wdata_q <= rx_byte;
                        wr_q    <= 1'b1;
                        state   <= ST_SKIP;
                    end
                    ST_RADDR: begin
                        addr_q <= rx_byte;
                        state  <= ST_RFILL;
                    end
                    ST_RFILL: begin
                        if (is_fill(rx_byte)) begin
                            ld_q     <= 1'b1;
                            ld_rev_q <= 1'b0;
                            state    <= ST_XFER;
                        end else begin
                            state    <= ST_SKIP;
                        end
                    end
                    ST_IFILL: begin
                        if (is_fill(rx_byte)) begin
                            ld_q     <= 1'b1;
                            ld_rev_q <= 1'b1;
                            state    <= ST_XFER;
                        end else begin
                            state    <= ST_SKIP;
                        end
                    end
                    default: state <= ST_SKIP;   // ST_XFER, ST_SKIP
                endcase
            end
        end
    end

    assign reg_addr  = addr_q;
    assign reg_wdata = wdata_q;
    assign reg_wr    = wr_q;
    assign reg_rd    = ld_q & ~ld_rev_q;
    assign tx_load   = ld_q;
    assign tx_data   = ld_rev_q ? REV_ID : reg_rdata;
endmodule

// File: rtl/spi_cmd_decoder.sv
module spi_cmd_decoder
    import spicd_pkg::*;
#(
    parameter int                SYNC_STAGES = 2,
    parameter logic [BYTE_W-1:0] REV_ID      = 8'h3A
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              spi_sclk,
    input  logic              spi_mosi,
    input  logic              spi_cs_n,
    output logic              spi_miso,
    output logic              led_n,
    output logic [BYTE_W-1:0] reg_addr,
    output logic [BYTE_W-1:0] reg_wdata,
    output logic              reg_wr,
    output logic              reg_rd,
    input  logic [BYTE_W-1:0] reg_rdata
);
    localparam int N_SYNC = 3;

    logic [N_SYNC-1:0] pins_raw;
    logic [N_SYNC-1:0] pins_s;
    spi_evt_t          evt;
    logic              cs_act;
    logic              byte_done;
    logic [BYTE_W-1:0] rx_byte;
    logic              tx_load;
    logic [BYTE_W-1:0] tx_data;
    logic              led_en;
    logic              led_q;

    assign pins_raw = {spi_cs_n, spi_mosi, spi_sclk};

    spicd_sync #(
        .W       (N_SYNC),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (3'b100)
    ) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (pins_raw),
        .q   (pins_s)
    );

    spicd_bitio u_bitio (
        .clk       (clk),
        .rst       (rst),
        .sclk_s    (pins_s[0]),
        .mosi_s    (pins_s[1]),
        .csn_s     (pins_s[2]),
        .tx_load   (tx_load),
        .tx_data   (tx_data),
        .evt       (evt),
        .byte_done (byte_done),
        .rx_byte   (rx_byte),
        .miso      (spi_miso)
    );

    assign cs_act = evt.act;

    spicd_cmd_fsm #(
        .REV_ID (REV_ID)
    ) u_fsm (
        .clk       (clk),
        .rst       (rst),
        .act       (cs_act),
        .byte_done (byte_done),
        .rx_byte   (rx_byte),
        .reg_rdata (reg_rdata),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_wr    (reg_wr),
        .reg_rd    (reg_rd),
        .tx_load   (tx_load),
        .tx_data   (tx_data),
        .led_en    (led_en)
    );

    always_ff @(posedge clk) begin
        if (rst) led_q <= 1'b1;
        else     led_q <= ~(led_en & cs_act);
    end
    assign led_n = led_q;
endmodule

// File: rtl/spicd_checker.sv
module spicd_checker (
    input logic clk,
    input logic rst,
    input logic cs_act,
    input logic led_en,
    input logic reg_wr,
    input logic reg_rd,
    input logic spi_miso,
    input logic led_n
);
    a_r12_strobe_excl: assert property (@(posedge clk) disable iff (rst)
        !(reg_wr && reg_rd));

    a_r12_wr_pulse: assert property (@(posedge clk) disable iff (rst)
        reg_wr |=> !reg_wr);

    a_r12_rd_pulse: assert property (@(posedge clk) disable iff (rst)
        reg_rd |=> !reg_rd);

    a_r11_miso_idle: assert property (@(posedge clk) disable iff (rst)
        !cs_act |=> spi_miso);

    a_r9_led_idle: assert property (@(posedge clk) disable iff (rst)
        !cs_act |=> led_n);

    a_r8_led_disabled: assert property (@(posedge clk) disable iff (rst)
        !led_en |=> led_n);

    a_r3_wr_in_frame: assert property (@(posedge clk) disable iff (rst)
        reg_wr |-> $past(cs_act));

    a_r5_rd_in_frame: assert property (@(posedge clk) disable iff (rst)
        reg_rd |-> $past(cs_act));
endmodule

bind spi_cmd_decoder spicd_checker u_spicd_checker (
    .clk      (clk),
    .rst      (rst),
    .cs_act   (cs_act),
    .led_en   (led_en),
    .reg_wr   (reg_wr),
    .reg_rd   (reg_rd),
    .spi_miso (spi_miso),
    .led_n    (led_n)
);

// File: tb/test_spi_cmd_decoder.sv
module test_spi_cmd_decoder;

    localparam int         HALF = 5;        // SCLK half period in system clocks
    localparam logic [7:0] REV  = 8'h3A;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       sclk = 1'b0;
    logic       mosi = 1'b0;
    logic       csn = 1'b1;
    logic       miso;
    logic       led_n;
    logic [7:0] reg_addr;
    logic [7:0] reg_wdata;
    logic       reg_wr;
    logic       reg_rd;
    logic [7:0] reg_rdata;

    always #5 clk = ~clk;

    spi_cmd_decoder #(.REV_ID(REV)) i_spi_cmd_decoder (
        .clk       (clk),
        .rst       (rst),
        .spi_sclk  (sclk),
        .spi_mosi  (mosi),
        .spi_cs_n  (csn),
        .spi_miso  (miso),
        .led_n     (led_n),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_wr    (reg_wr),
        .reg_rd    (reg_rd),
        .reg_rdata (reg_rdata)
    );

    // register file model driven by the bus, and the bench's own expectation
    logic [7:0] rf [256];
    logic [7:0] em [256];
    int         wr_cnt = 0;
    int         rd_cnt = 0;
    logic [7:0] last_ra = '0;

    assign reg_rdata = rf[reg_addr];

    always @(posedge clk) begin
        if (!rst) begin
            if (reg_wr) begin
                rf[reg_addr] <= reg_wdata;
                wr_cnt       <= wr_cnt + 1;
            end
            if (reg_rd) begin
                rd_cnt  <= rd_cnt + 1;
                last_ra <= reg_addr;
            end
        end
    end

    int         checks = 0;
    int         errors = 0;
    bit         done   = 1'b0;
    logic [7:0] txb [6];
    logic [7:0] rxb [6];
    logic       led_seen;

    function automatic logic [7:0] init_val(input int a);
        return 8'((a * 7 + 13) ^ 8'h5A);
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    // n bytes from txb, the last byte cut to last_bits bits
    task automatic frame(input int n, input int last_bits = 8);
        @(negedge clk) csn = 1'b0;
        repeat (4) @(negedge clk);
        led_seen = led_n;
        for (int k = 0; k < n; k++) begin
            int nb = (k == n - 1) ? last_bits : 8;
            rxb[k] = 8'hFF;
            for (int i = 0; i < nb; i++) begin
                mosi = txb[k][7 - i];
                repeat (HALF) @(negedge clk);
                rxb[k][7 - i] = miso;
                sclk = 1'b1;
                repeat (HALF) @(negedge clk);
                sclk = 1'b0;
            end
        end
        repeat (HALF) @(negedge clk);
        csn = 1'b1;
        repeat (8) @(negedge clk);
    endtask

    task automatic do_write(input logic [7:0] a, input logic [7:0] d);
        int w0 = wr_cnt;
        txb[0] = 8'h01; txb[1] = a; txb[2] = d;
        frame(3);
        em[a] = d;
        chk("R3 write count", wr_cnt, w0 + 1);
        chk("R3 written value", rf[a], d);
    endtask

    task automatic do_read(input logic [7:0] a);
        int r0 = rd_cnt;
        txb[0] = 8'h05; txb[1] = a; txb[2] = 8'hFF; txb[3] = 8'h00;
        frame(4);
        chk("R5 read count", rd_cnt, r0 + 1);
        chk("R5 read addr", last_ra, a);
        chk("R2 R5 read data MSB first", rxb[3], em[a]);
        chk("R11 miso idle before data", {rxb[0], rxb[1], rxb[2]}, 24'hFFFFFF);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog actual=timeout expected=finish");
        finish_run();
    end

    initial begin
        int w0;
        int r0;
        int unsigned seed;
        for (int a = 0; a < 256; a++) begin
            rf[a] = init_val(a);
            em[a] = init_val(a);
        end
        seed = $urandom(32'h5EED);
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        chk("R1 miso", miso, 1);
        chk("R1 led_n", led_n, 1);
        chk("R1 reg_wr", reg_wr, 0);
        chk("R1 reg_rd", reg_rd, 0);

        // R3 / R5 / R2 directed
        do_write(8'h3C, 8'hA5);
        chk("R9 led low in frame", led_seen, 0);
        chk("R9 led high idle", led_n, 1);
        do_read(8'h3C);
        do_write(8'h81, 8'h01);
        do_read(8'h81);

        // R6 bad stuffing byte
        r0 = rd_cnt;
        txb[0] = 8'h05; txb[1] = 8'h3C; txb[2] = 8'h00; txb[3] = 8'h00;
        frame(4);
        chk("R6 no read strobe", rd_cnt, r0);
        chk("R6 miso stays high", rxb[3], 8'hFF);

        // R4 truncated write, then read back
        w0 = wr_cnt;
        txb[0] = 8'h01; txb[1] = 8'h40; txb[2] = 8'h77;
        frame(3, 5);
        chk("R4 no write strobe", wr_cnt, w0);
        chk("R4 register kept", rf[8'h40], em[8'h40]);
        do_read(8'h40);
        txb[0] = 8'h01; txb[1] = 8'h40; txb[2] = 8'h77;
        frame(2);
        chk("R4 addr-only no write", wr_cnt, w0);

        // R7 revision
        r0 = rd_cnt;
        w0 = wr_cnt;
        txb[0] = 8'h9F; txb[1] = 8'hFF; txb[2] = 8'h00;
        frame(3);
        chk("R7 revision byte", rxb[2], REV);
        chk("R7 no read strobe", rd_cnt, r0);
        chk("R7 no write strobe", wr_cnt, w0);

        // R10 unsupported opcodes followed by a write-like tail
        txb[0] = 8'h02; txb[1] = 8'h01; txb[2] = 8'h50; txb[3] = 8'h11;
        frame(4);
        chk("R10 no write after bad opcode", wr_cnt, w0);
        chk("R10 miso all ones", {rxb[0], rxb[1], rxb[2], rxb[3]}, 32'hFFFFFFFF);
        chk("R10 register untouched", rf[8'h50], em[8'h50]);
        txb[0] = 8'h00; txb[1] = 8'h05; txb[2] = 8'h50; txb[3] = 8'hFF; txb[4] = 8'h00;
        frame(5);
        chk("R10 no read after zero opcode", rd_cnt, r0);
        chk("R10 miso ones zero opcode", rxb[4], 8'hFF);

        // R13 extra bytes after a write and after a read
        w0 = wr_cnt;
        txb[0] = 8'h01; txb[1] = 8'h60; txb[2] = 8'h22;
        txb[3] = 8'h01; txb[4] = 8'h61; txb[5] = 8'h33;
        frame(6);
        em[8'h60] = 8'h22;
        chk("R13 single write", wr_cnt, w0 + 1);
        chk("R13 tail ignored", rf[8'h61], em[8'h61]);
        txb[0] = 8'h05; txb[1] = 8'h60; txb[2] = 8'hFF; txb[3] = 8'h00; txb[4] = 8'h00;
        frame(5);
        chk("R13 read data", rxb[3], 8'h22);
        chk("R11 miso high after data", rxb[4], 8'hFF);

        // R8 LED off / on
        txb[0] = 8'h06;
        frame(1);
        do_write(8'h10, 8'h5F);
        chk("R8 led stays off", led_seen, 1);
        txb[0] = 8'h04;
        frame(1);
        do_write(8'h11, 8'hC3);
        chk("R8 led back on", led_seen, 0);

        // random mix
        for (int it = 0; it < 40; it++) begin
            logic [7:0] a = 8'($urandom);
            logic [7:0] d = 8'($urandom);
            case ($urandom % 3)
                0: do_write(a, d);
                1: do_read(a);
                default: begin
                    r0 = rd_cnt;
                    txb[0] = 8'h9F; txb[1] = 8'hFF; txb[2] = d;
                    frame(3);
                    chk("R7 random revision", rxb[2], REV);
                    chk("R7 random no read", rd_cnt, r0);
                end
            endcase
        end

        chk("R11 miso idle at end", miso, 1);
        finish_run();
    end
endmodule